// File: doc/BRIEF.md
# Serial-In Parallel-Out Latched Shifter

This block takes a serial bit stream into a shift stage and, on a separate clock, copies the whole shift stage into a storage stage. The storage stage drives the parallel outputs. These outputs can be put into a high-impedance state, so several blocks can share one parallel bus. The last bit of the shift stage is brought out on its own output. Several blocks can then be chained serially, and one shared storage clock updates all of them together.

The shift stage has an active-low asynchronous clear that does not touch the storage stage. The two clocks are independent rising-edge clocks. When they are tied together, the outputs show the shift contents from one edge earlier.

Top module: `latched_serial_shifter`

## Requirements
- R1: On each rising edge of `shift_clk_i` with `rst_ni` high, `ser_i` enters shift bit 0 and every shift bit i moves to bit i+1. The old bit 7 is dropped.
- R2: `cas_o` always equals shift bit 7 and is always driven, never high impedance. Feeding `cas_o` into the `ser_i` of a second block gives a 16-bit chain.
- R3: On each rising edge of `store_clk_i`, storage bit i takes shift bit i for all 8 bits. `par_o[i]` shows storage bit i.
- R4: A shift edge alone leaves `par_o` unchanged, and a store edge alone leaves the shift stage unchanged.
- R5: While `rst_ni` is low, all shift bits are zero at once, whatever the clock or `ser_i` does. The storage stage and `par_o` keep their values.
- R6: While `oe_ni` is high, all eight `par_o` bits are high impedance. While it is low, they drive the storage contents.
- R7: While `oe_ni` is high, the storage stage still loads on `store_clk_i` and keeps its contents. The loaded value appears on `par_o` once `oe_ni` goes low.
- R8: With both clocks on one signal, each edge loads the storage stage with the shift contents from before that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk_i | input | 1 | Shift stage clock, rising edge |
| store_clk_i | input | 1 | Storage stage clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous clear of the shift stage only |
| oe_ni | input | 1 | Active-low output enable for `par_o` |
| ser_i | input | 1 | Serial data input |
| par_o | output | 8 | Tri-state parallel outputs from the storage stage |
| cas_o | output | 1 | Serial cascade output (shift bit 7) |

## Verification
`cas_o` follows a shift edge with no added delay, and `par_o` follows a store edge the same way. The clear and `oe_ni` act combinationally, without any clock. The bench raises each clock pulse away from its reference clock edge and updates its behavioural model at that pulse. It then compares every output a few nanoseconds later, after the pulse has ended and before the next pulse. The high-impedance state is probed by having the bench drive two complementary patterns onto the bus: the patterns come back unchanged only if the block has let go of the bus.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int unsigned LSS_WIDTH = 8;
  typedef logic [LSS_WIDTH-1:0] lss_word_t;
endpackage

// File: rtl/lss_shift_stage.sv
module lss_shift_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  output logic [WIDTH-1:0] q_o,
  output logic             cas_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] sh_q;
  logic [WIDTH-1:0] sh_d;

  generate
    if (WIDTH == 1) begin : g_one
      assign sh_d = ser_i;
    end else begin : g_many
      assign sh_d = {sh_q[MSB-1:0], ser_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign q_o   = sh_q;
  assign cas_o = sh_q[MSB];

  // clear overrides clock
  p_clear_r5: assert property (@(posedge clk_i) !rst_ni |-> (q_o == '0));
  p_clear_cas_r5: assert property (@(posedge clk_i) !rst_ni |-> !cas_o);
  p_known_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) !$isunknown(cas_o));
endmodule

// File: rtl/lss_store_stage.sv
module lss_store_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] st_q;

  // no reset by design: the shift clear must not disturb held outputs
  always_ff @(posedge clk_i) st_q <= d_i;

  assign q_o = st_q;

  p_load_r3: assert property (@(posedge clk_i) 1'b1 |=> (q_o == $past(d_i)));
endmodule

// File: rtl/lss_tri_drv.sv
module lss_tri_drv #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] pad_o
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign pad_o[i] = oe_ni ? 1'bz : d_i[i];
    end
  endgenerate
endmodule

// File: rtl/latched_serial_shifter.sv
module latched_serial_shifter
  import lss_pkg::*;
(
  input  logic                 shift_clk_i,
  input  logic                 store_clk_i,
  input  logic                 rst_ni,
  input  logic                 oe_ni,
  input  logic                 ser_i,
  output logic [LSS_WIDTH-1:0] par_o,
  output logic                 cas_o
);
  lss_word_t sh_word;
  lss_word_t st_word;

  lss_shift_stage #(.WIDTH(LSS_WIDTH)) u_shift (
    .clk_i  (shift_clk_i),
    .rst_ni (rst_ni),
    .ser_i  (ser_i),
    .q_o    (sh_word),
    .cas_o  (cas_o)
  );

  lss_store_stage #(.WIDTH(LSS_WIDTH)) u_store (
    .clk_i (store_clk_i),
    .d_i   (sh_word),
    .q_o   (st_word)
  );

  lss_tri_drv #(.WIDTH(LSS_WIDTH)) u_drv (
    .oe_ni (oe_ni),
    .d_i   (st_word),
    .pad_o (par_o)
  );
endmodule

// File: tb/latched_serial_shifter_bench.sv
`timescale 1ns/1ps
module latched_serial_shifter_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic sh_clk = 1'b0, st_clk = 1'b0, rst_n = 1'b0, oe_n = 1'b0, ser = 1'b0;
  logic cas0, cas1;
  wire [7:0] par0_w, par1_w;
  logic probe_en = 1'b0;
  logic [7:0] probe_pat = 8'h00;

  assign par0_w = probe_en ? probe_pat : 8'bz;
  assign par1_w = probe_en ? probe_pat : 8'bz;

  latched_serial_shifter u_latched_serial_shifter (
    .shift_clk_i(sh_clk), .store_clk_i(st_clk), .rst_ni(rst_n), .oe_ni(oe_n),
    .ser_i(ser), .par_o(par0_w), .cas_o(cas0)
  );
  latched_serial_shifter u_latched_serial_shifter_b (
    .shift_clk_i(sh_clk), .store_clk_i(st_clk), .rst_ni(rst_n), .oe_ni(oe_n),
    .ser_i(cas0), .par_o(par1_w), .cas_o(cas1)
  );

  // reference model: chain as 16-bit value, bits 0..7 first block
  logic [15:0] m_sh = 16'h0000;
  logic [15:0] m_st = 16'h0000;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " cas0"}, {7'd0, cas0}, {7'd0, m_sh[7]});
    chk({tag, " cas1"}, {7'd0, cas1}, {7'd0, m_sh[15]});
    if (!oe_n) begin
      chk({tag, " par0"}, par0_w, m_st[7:0]);
      chk({tag, " par1"}, par1_w, m_st[15:8]);
    end else begin
      probe_en = 1'b1; probe_pat = 8'hA5; #0.5;
      chk({tag, " R6 hiz0 a"}, par0_w, 8'hA5);
      chk({tag, " R6 hiz1 a"}, par1_w, 8'hA5);
      probe_pat = 8'h5A; #0.5;
      chk({tag, " R6 hiz0 b"}, par0_w, 8'h5A);
      chk({tag, " R6 hiz1 b"}, par1_w, 8'h5A);
      probe_en = 1'b0; #0.5;
    end
  endtask

  task automatic pulse(input bit dsh, input bit dst, input bit s, input string tag);
    logic [15:0] old;
    @(posedge clk);
    #1 ser = s;
    #1;
    old = m_sh;
    if (dst) m_st = old;
    if (dsh && rst_n) m_sh = {old[14:0], s};
    sh_clk = dsh; st_clk = dst;
    #1 sh_clk = 1'b0; st_clk = 1'b0;
    #1 compare(tag);
  endtask

  task automatic shift_word(input logic [15:0] w, input string tag);
    for (int i = 15; i >= 0; i--) pulse(1'b1, 1'b0, w[i], tag);
  endtask

  initial begin
    // R5 reset state: shift zero, storage loads zeros
    #10;
    pulse(1'b0, 1'b1, 1'b0, "R5 reset load");
    @(negedge clk) rst_n = 1'b1;
    // R1/R2/R4: 16-bit serial transfer, outputs hold during shifting
    shift_word(16'hB38D, "R1 R2 R4 shift");
    chk("R2 chain low", {7'd0, cas0}, {7'd0, m_sh[7]});
    pulse(1'b0, 1'b1, 1'b0, "R3 store");
    chk("R3 full word", par1_w, 8'hB3);
    chk("R3 full word lo", par0_w, 8'h8D);
    // R4: store alone leaves shift stage
    pulse(1'b0, 1'b1, 1'b1, "R4 store only");
    pulse(1'b1, 1'b0, 1'b0, "R4 shift only");
    // R8: tied clocks, one-edge lag
    for (int i = 0; i < 12; i++) pulse(1'b1, 1'b1, ((i % 3) != 0), "R8 tied");
    // R5: clear in mid-shift, storage keeps value
    shift_word(16'hF0F0, "R1 prefill");
    pulse(1'b0, 1'b1, 1'b0, "R3 store prefill");
    pulse(1'b1, 1'b0, 1'b1, "R1 partial");
    pulse(1'b1, 1'b0, 1'b1, "R1 partial");
    @(negedge clk);
    #1 rst_n = 1'b0; m_sh = 16'h0000;
    #1 compare("R5 mid clear");
    pulse(1'b1, 1'b0, 1'b1, "R5 clear holds vs clock");
    @(negedge clk) rst_n = 1'b1;
    pulse(1'b0, 1'b1, 1'b0, "R5 store after clear");
    // R6/R7: high impedance, load while disabled
    shift_word(16'hC33C, "R1 load");
    pulse(1'b0, 1'b1, 1'b0, "R3 store");
    @(negedge clk) oe_n = 1'b1;
    #1 compare("R6 disabled");
    shift_word(16'h69E1, "R7 shift while off");
    pulse(1'b0, 1'b1, 1'b0, "R7 store while off");
    @(negedge clk) oe_n = 1'b0;
    #1 compare("R7 reenabled");
    chk("R7 value lo", par0_w, 8'hE1);
    chk("R7 value hi", par1_w, 8'h69);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule